// File: doc/BRIEF.md
# PHY Management Register File

This block holds the four basic management registers of a 10/100 Ethernet physical-layer device: control (00h), status (01h), ability advertisement (04h) and link partner ability (05h). Software reaches them through a simple parallel port with a 5-bit address, a write enable and a combinational read path. The serial management framing sits outside the block and drives this port. The negotiation engine supplies live status and the partner's ability word. The block hands back the resolved speed and duplex, plus a one-cycle restart strobe.

There are two ways to reset the block. The first is an active-low hardware reset pin with a minimum-width filter. The second is a self-clearing software reset bit, which keeps reading 1 for a fixed number of cycles. Strap pins are sampled while an accepted hardware reset is in progress, and they set the register defaults. The sampled levels are kept, so a later software reset rebuilds the same defaults even after the strap pins have turned into outputs. While autonegotiation is enabled, the block compares the advertised abilities with the partner's abilities and picks the best common mode by a fixed priority.

Top module: `phy_mgmt_regs`

## Requirements
- R1: A hardware reset is accepted only if `hwRstN` is sampled low at HW_RST_MIN (default 16) consecutive rising edges. From the HW_RST_MIN-th such edge onward, all registers load their defaults on every edge while the pin stays low. A shorter low pulse changes no register.
- R2: Each edge of an accepted hardware reset samples `strapIn` and keeps the result. The default mapping is: strap bit 0 sets control bit 12, strap bit 1 sets control bit 13, strap bit 2 sets control bit 8, and strap bit 3 = 1 clears advertisement bits 8 and 7. A software reset uses the kept strap values, not the current pins.
- R3: A write to 00h with bit 15 = 1, made while no reset is active, loads every register with its defaults on that edge. Bit 15 then reads 1 for exactly SW_RST_CYCLES (default 8) cycles and then reads 0. Register writes during that time are ignored.
- R4: `coreRst` is 1 while an accepted hardware reset is active and while a software reset is counting. Otherwise it is 0.
- R5: Status 01h reads 1 in bits 15:11, bit 3 and bit 0. It reads `anComplete` in bit 5, `remoteFault` in bit 4 and `linkUp` in bit 2, with every other bit 0. Writes to 01h have no effect.
- R6: Partner register 05h takes `partnerIn` on a cycle with `partnerLoad` high and is cleared by any reset. Software writes to 05h are ignored.
- R7: Advertisement 04h has writable bits 8 (100 Mb/s full duplex), 7 (100 Mb/s half duplex), 6 (10 Mb/s full duplex) and 5 (10 Mb/s half duplex). Bits 4:0 read 00001 and all other bits read 0. The default with strap bit 3 = 0 is 01E1h.
- R8: In control 00h, bit 13 (speed 100), bit 12 (autonegotiation enable) and bit 8 (full duplex) are read/write. Every other bit except 15 and 9 reads 0.
- R9: A write to 00h with bit 9 = 1 makes bit 9 read 1 for one cycle, after which it clears itself. `anRestartStrobe` is high in that cycle only if bit 12 is 1.
- R10: With bit 12 = 0, `cfgSpeed100` follows control bit 13 and `cfgFullDuplex` follows control bit 8.
- R11: With bit 12 = 1 and `anComplete` = 1, the outputs take the highest common ability of 04h and 05h. The priority order is bit 8 (speed and duplex 1,1), then bit 7 (1,0), then bit 6 (0,1). Bit 6 being absent, or `anComplete` = 0, gives 0,0.
- R12: Any address other than 00h, 01h, 04h or 05h reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| hwRstN | input | 1 | Active-low hardware reset pin |
| strapIn | input | 4 | Strap levels: anEnable, speed100, fullDup, suppress100 |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 5 | Register address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr |
| anComplete | input | 1 | Negotiation engine reports completion |
| remoteFault | input | 1 | Partner signals a remote fault |
| linkUp | input | 1 | Valid link present |
| partnerLoad | input | 1 | Capture partnerIn into 05h |
| partnerIn | input | 16 | Partner ability word |
| cfgSpeed100 | output | 1 | Resolved speed, 1 = 100 Mb/s |
| cfgFullDuplex | output | 1 | Resolved duplex, 1 = full |
| anRestartStrobe | output | 1 | One-cycle negotiation restart |
| coreRst | output | 1 | Reset to the rest of the device |

## Verification
Mode resolution is driven with partner words whose highest common bit is 8, then 7, then 6, then 5, then none. This separates each step of the priority chain. A reduced advertisement is also applied, which shows that the advertised side is masked and not only the partner side. The reset paths are exercised with long and short hardware pulses, and the strap pins are changed between resets. This tells the two possible strap sources apart and shows whether the filter really holds off. Back-to-back software reset writes show whether writes are blocked during the count.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 5;
  localparam int STRAP_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 5'h01;
  localparam logic [ADDR_W-1:0] ADDR_ADV  = 5'h04;
  localparam logic [ADDR_W-1:0] ADDR_PART = 5'h05;

  localparam int CB_SWRST   = 15;
  localparam int CB_SPEED   = 13;
  localparam int CB_ANEN    = 12;
  localparam int CB_RESTART = 9;
  localparam int CB_DUPLEX  = 8;

  localparam int AB_100FD = 8;
  localparam int AB_100HD = 7;
  localparam int AB_10FD  = 6;
  localparam int AB_10HD  = 5;
  localparam int ABIL_W   = AB_100FD - AB_10HD + 1;

  localparam logic [4:0] SELECTOR = 5'b00001;

  typedef struct packed {
    logic suppress100;
    logic fullDup;
    logic speed100;
    logic anEnable;
  } strapSet_t;

  typedef struct packed {
    logic live;
    logic loadDefaults;
    logic swBusy;
    logic wrCtrl;
    logic wrAdv;
  } mgmtStrobes_t;
endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int HW_RST_MIN    = 16,
  parameter int SW_RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              hwRstN,
  input  strapSet_t         strapIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              swRstBit,
  output mgmtStrobes_t      st,
  output strapSet_t         dflt,
  output logic              coreRst
);
  localparam int LOW_W = $clog2(HW_RST_MIN) + 1;
  localparam int SW_W  = $clog2(SW_RST_CYCLES + 1);
  localparam logic [LOW_W-1:0] LOW_SAT = LOW_W'(HW_RST_MIN - 1);

  logic [LOW_W-1:0] lowCnt;
  logic [SW_W-1:0]  swCnt;
  strapSet_t        strapQ;
  logic             armed;
  logic             hwHold, swBusy, swStart, ctrlHit, advHit;

  assign hwHold  = !hwRstN && (lowCnt >= LOW_SAT);
  assign swBusy  = (swCnt != '0);
  assign ctrlHit = regWrEn && (regAddr == ADDR_CTRL);
  assign advHit  = regWrEn && (regAddr == ADDR_ADV);
  assign swStart = ctrlHit && swRstBit && !swBusy && !hwHold;

  // low-pulse width filter on the reset pin
  always_ff @(posedge clk) begin
    if (hwRstN)               lowCnt <= '0;
    else if (lowCnt < LOW_SAT) lowCnt <= lowCnt + 1'b1;
  end

  // software reset sequencer
  always_ff @(posedge clk) begin
    if (hwHold)       swCnt <= '0;
    else if (swStart) swCnt <= SW_W'(SW_RST_CYCLES);
    else if (swBusy)  swCnt <= swCnt - 1'b1;
  end

  // strap capture during accepted hardware reset
  always_ff @(posedge clk) begin
    if (hwHold) strapQ <= strapIn;
    armed <= armed | hwHold;
  end

  assign dflt = hwHold ? strapIn : strapQ;

  always_comb begin
    st.live         = armed;
    st.loadDefaults = hwHold || swBusy || swStart;
    st.swBusy       = swBusy;
    st.wrCtrl       = ctrlHit && !swBusy && !hwHold;
    st.wrAdv        = advHit && !swBusy && !hwHold;
  end

  assign coreRst = hwHold || swBusy;

  generate
    if (HW_RST_MIN > 1) begin : g_filterChk
      // R1
      hw_filter_chk: assert property (@(posedge clk) disable iff (!armed)
        hwHold |-> $past(!hwRstN));
    end
  endgenerate

  // R3
  sw_len_chk: assert property (@(posedge clk) disable iff (!armed)
    (swBusy && !hwHold) |=> (swCnt == $past(swCnt) - 1'b1));

  // R3
  sw_start_chk: assert property (@(posedge clk) disable iff (!armed)
    swStart |=> swBusy);
endmodule

// File: rtl/phy_mgmt_dp.sv
module phy_mgmt_dp
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  mgmtStrobes_t      st,
  input  strapSet_t         dflt,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              anComplete,
  input  logic              remoteFault,
  input  logic              linkUp,
  input  logic              partnerLoad,
  input  logic [REG_W-1:0]  partnerIn,
  output logic [REG_W-1:0]  regRdData,
  output logic              cfgSpeed100,
  output logic              cfgFullDuplex,
  output logic              anRestartStrobe
);
  logic              speedQ, anEnQ, duplexQ, restartQ;
  logic [ABIL_W-1:0] advQ;
  logic [REG_W-1:0]  partQ;
  logic [ABIL_W-1:0] common;
  logic [REG_W-1:0]  ctrlWord, statWord, advWord;

  always_ff @(posedge clk) begin
    if (st.loadDefaults) begin
      speedQ   <= dflt.speed100;
      anEnQ    <= dflt.anEnable;
      duplexQ  <= dflt.fullDup;
      restartQ <= 1'b0;
      advQ     <= {!dflt.suppress100, !dflt.suppress100, 2'b11};
      partQ    <= '0;
    end else begin
      restartQ <= st.wrCtrl && regWrData[CB_RESTART];
      if (st.wrCtrl) begin
        speedQ  <= regWrData[CB_SPEED];
        anEnQ   <= regWrData[CB_ANEN];
        duplexQ <= regWrData[CB_DUPLEX];
      end
      if (st.wrAdv) advQ <= regWrData[AB_100FD:AB_10HD];
      if (partnerLoad) partQ <= partnerIn;
    end
  end

  assign ctrlWord = {st.swBusy, 1'b0, speedQ, anEnQ, 2'b00, restartQ, duplexQ, 8'h00};
  assign statWord = {5'b11111, 5'b00000, anComplete, remoteFault, 1'b1, linkUp, 1'b0, 1'b1};
  assign advWord  = {7'b0000000, advQ, SELECTOR};

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = ctrlWord;
      ADDR_STAT: regRdData = statWord;
      ADDR_ADV:  regRdData = advWord;
      ADDR_PART: regRdData = partQ;
      default:   regRdData = '0;
    endcase
  end

  // best common ability, highest bit wins
  assign common = advQ & partQ[AB_100FD:AB_10HD];

  always_comb begin
    cfgSpeed100   = 1'b0;
    cfgFullDuplex = 1'b0;
    if (!anEnQ) begin
      cfgSpeed100   = speedQ;
      cfgFullDuplex = duplexQ;
    end else if (anComplete) begin
      if (common[AB_100FD-AB_10HD]) begin
        cfgSpeed100   = 1'b1;
        cfgFullDuplex = 1'b1;
      end else if (common[AB_100HD-AB_10HD]) begin
        cfgSpeed100   = 1'b1;
      end else if (common[AB_10FD-AB_10HD]) begin
        cfgFullDuplex = 1'b1;
      end
    end
  end

  assign anRestartStrobe = restartQ && anEnQ;

  // R6
  part_hold_chk: assert property (@(posedge clk) disable iff (!st.live)
    (!st.loadDefaults && !partnerLoad) |=> $stable(partQ));

  // R9
  restart_sc_chk: assert property (@(posedge clk) disable iff (!st.live)
    (restartQ && !(st.wrCtrl && regWrData[CB_RESTART])) |=> !restartQ);

  // R3
  dflt_ctrl_chk: assert property (@(posedge clk) disable iff (!st.live)
    st.loadDefaults |=> (anEnQ == $past(dflt.anEnable)) && (speedQ == $past(dflt.speed100)));

  // R7
  adv_wr_chk: assert property (@(posedge clk) disable iff (!st.live)
    (st.wrAdv && !st.loadDefaults) |=> (advQ == $past(regWrData[AB_100FD:AB_10HD])));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int HW_RST_MIN    = 16,
  parameter int SW_RST_CYCLES = 8
) (
  input  logic                clk,
  input  logic                hwRstN,
  input  logic [STRAP_W-1:0]  strapIn,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic                anComplete,
  input  logic                remoteFault,
  input  logic                linkUp,
  input  logic                partnerLoad,
  input  logic [REG_W-1:0]    partnerIn,
  output logic                cfgSpeed100,
  output logic                cfgFullDuplex,
  output logic                anRestartStrobe,
  output logic                coreRst
);
  mgmtStrobes_t st;
  strapSet_t    dflt;
  strapSet_t    strapBus;

  assign strapBus = strapSet_t'(strapIn);

  phy_mgmt_ctrl #(
    .HW_RST_MIN   (HW_RST_MIN),
    .SW_RST_CYCLES(SW_RST_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .hwRstN  (hwRstN),
    .strapIn (strapBus),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .swRstBit(regWrData[CB_SWRST]),
    .st      (st),
    .dflt    (dflt),
    .coreRst (coreRst)
  );

  phy_mgmt_dp u_dp (
    .clk            (clk),
    .st             (st),
    .dflt           (dflt),
    .regAddr        (regAddr),
    .regWrData      (regWrData),
    .anComplete     (anComplete),
    .remoteFault    (remoteFault),
    .linkUp         (linkUp),
    .partnerLoad    (partnerLoad),
    .partnerIn      (partnerIn),
    .regRdData      (regRdData),
    .cfgSpeed100    (cfgSpeed100),
    .cfgFullDuplex  (cfgFullDuplex),
    .anRestartStrobe(anRestartStrobe)
  );
endmodule

// File: tb/tb_phy_mgmt_regs.sv
`timescale 1ns/1ps
module tb_phy_mgmt_regs;
  localparam int HWMIN = 16;
  localparam int SWCYC = 8;

  logic        clk = 1'b0;
  logic        hwRstN = 1'b1;
  logic [3:0]  strapIn = 4'b0001;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = 5'h00;
  logic [15:0] regWrData = 16'h0000;
  logic [15:0] regRdData;
  logic        anComplete = 1'b0, remoteFault = 1'b0, linkUp = 1'b0;
  logic        partnerLoad = 1'b0;
  logic [15:0] partnerIn = 16'h0000;
  logic        cfgSpeed100, cfgFullDuplex, anRestartStrobe, coreRst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  phy_mgmt_regs dut (
    .clk(clk), .hwRstN(hwRstN), .strapIn(strapIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .anComplete(anComplete), .remoteFault(remoteFault), .linkUp(linkUp),
    .partnerLoad(partnerLoad), .partnerIn(partnerIn),
    .cfgSpeed100(cfgSpeed100), .cfgFullDuplex(cfgFullDuplex),
    .anRestartStrobe(anRestartStrobe), .coreRst(coreRst)
  );

  // behavioural reference model
  int        mLowRun = 0;
  int        mSwCnt = 0;
  bit [3:0]  mStrapQ = 4'b0000;
  bit        mArmed = 0;
  bit        mSpeed, mAnEn, mDup, mRestart;
  bit [15:0] mAdv, mPart;

  function automatic bit mHwHold();
    return (hwRstN == 1'b0) && (mLowRun >= HWMIN - 1);
  endfunction

  function automatic bit [15:0] mRead(input bit [4:0] a);
    case (a)
      5'h00: return {(mSwCnt != 0), 1'b0, mSpeed, mAnEn, 2'b00, mRestart, mDup, 8'h00};
      5'h01: return 16'hF809 | {10'b0, anComplete, remoteFault, 1'b0, linkUp, 2'b00};
      5'h04: return mAdv;
      5'h05: return mPart;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic bit [1:0] mMode();
    bit [15:0] c;
    c = mAdv & mPart;
    if (!mAnEn) return {mSpeed, mDup};
    if (!anComplete) return 2'b00;
    if (c[8]) return 2'b11;
    if (c[7]) return 2'b10;
    if (c[6]) return 2'b01;
    return 2'b00;
  endfunction

  always @(posedge clk) begin
    bit hold, start, load;
    bit [3:0] ds;
    hold  = mHwHold();
    start = !hold && (mSwCnt == 0) && regWrEn && (regAddr == 5'h00) && regWrData[15];
    load  = hold || (mSwCnt != 0) || start;
    ds    = hold ? strapIn : mStrapQ;
    if (load) begin
      mAnEn = ds[0]; mSpeed = ds[1]; mDup = ds[2]; mRestart = 0;
      mAdv  = ds[3] ? 16'h0061 : 16'h01E1;
      mPart = 16'h0000;
    end else begin
      mRestart = 0;
      if (regWrEn && regAddr == 5'h00) begin
        mSpeed = regWrData[13]; mAnEn = regWrData[12];
        mDup = regWrData[8]; mRestart = regWrData[9];
      end
      if (regWrEn && regAddr == 5'h04) mAdv = {7'b0, regWrData[8:5], 5'b00001};
      if (partnerLoad) mPart = partnerIn;
    end
    if (hold) mSwCnt = 0;
    else if (start) mSwCnt = SWCYC;
    else if (mSwCnt != 0) mSwCnt = mSwCnt - 1;
    if (hold) mStrapQ = strapIn;
    mLowRun = hwRstN ? 0 : mLowRun + 1;
    mArmed = mArmed | hold;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (mArmed && !done) begin
      bit [1:0] md;
      string rt;
      case (regAddr)
        5'h00: rt = "R8 ctrl read";
        5'h01: rt = "R5 status read";
        5'h04: rt = "R7 adv read";
        5'h05: rt = "R6 partner read";
        default: rt = "R12 unmapped read";
      endcase
      chk(rt, regRdData, mRead(regAddr));
      md = mMode();
      chk(mAnEn ? "R11 resolved mode" : "R10 forced mode",
          {14'b0, cfgSpeed100, cfgFullDuplex}, {14'b0, md});
      chk("R9 restart strobe", {15'b0, anRestartStrobe}, {15'b0, mRestart & mAnEn});
      chk("R4 core reset", {15'b0, coreRst}, {15'b0, mHwHold() || (mSwCnt != 0)});
    end
  end

  task automatic wr(input bit [4:0] a, input bit [15:0] d);
    @(posedge clk); #2;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #2;
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input bit [4:0] a, input bit [15:0] exp);
    @(posedge clk); #2;
    regAddr = a;
    @(negedge clk);
    chk(tag, regRdData, exp);
  endtask

  task automatic pload(input bit [15:0] v);
    @(posedge clk); #2;
    partnerLoad = 1'b1; partnerIn = v;
    @(posedge clk); #2;
    partnerLoad = 1'b0;
  endtask

  task automatic modeChk(input string tag, input bit [1:0] exp);
    @(negedge clk);
    chk(tag, {14'b0, cfgSpeed100, cfgFullDuplex}, {14'b0, exp});
  endtask

  task automatic hwPulse(input int n, input bit expRst);
    @(posedge clk); #2;
    hwRstN = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    chk("R4 coreRst during pin low", {15'b0, coreRst}, {15'b0, expRst});
    @(posedge clk); #2;
    hwRstN = 1'b1;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    hwPulse(20, 1'b1);
    repeat (2) @(posedge clk);

    // reset state
    rdChk("R2 ctrl default straps 0001", 5'h00, 16'h1000);
    rdChk("R7 adv default", 5'h04, 16'h01E1);
    rdChk("R6 partner cleared", 5'h05, 16'h0000);
    rdChk("R5 status idle", 5'h01, 16'hF809);

    // status live bits and read-only
    @(posedge clk); #2; linkUp = 1; remoteFault = 1; anComplete = 1;
    rdChk("R5 status live", 5'h01, 16'hF83D);
    wr(5'h01, 16'h0000);
    rdChk("R5 status write ignored", 5'h01, 16'hF83D);

    // partner register
    pload(16'h0181);
    rdChk("R6 partner captured", 5'h05, 16'h0181);
    wr(5'h05, 16'hFFFF);
    rdChk("R6 partner write ignored", 5'h05, 16'h0181);

    // priority resolution
    modeChk("R11 100 full", 2'b11);
    pload(16'h0081); modeChk("R11 100 half", 2'b10);
    pload(16'h0041); modeChk("R11 10 full", 2'b01);
    pload(16'h0021); modeChk("R11 10 half", 2'b00);
    pload(16'h0001); modeChk("R11 no common", 2'b00);
    wr(5'h04, 16'h0060);
    rdChk("R7 adv write", 5'h04, 16'h0061);
    wr(5'h04, 16'hFFFF);
    rdChk("R7 adv fixed bits", 5'h04, 16'h01E1);
    wr(5'h04, 16'h0060);
    pload(16'h01E1); modeChk("R11 adv masks 100", 2'b01);
    @(posedge clk); #2; anComplete = 0;
    modeChk("R11 incomplete", 2'b00);
    @(posedge clk); #2; anComplete = 1;

    // restart
    wr(5'h00, 16'h1200);
    @(negedge clk);
    chk("R9 restart bit set", regRdData, 16'h1200);
    chk("R9 strobe with an enabled", {15'b0, anRestartStrobe}, 16'h0001);
    @(negedge clk);
    chk("R9 restart self-clear", regRdData, 16'h1000);
    wr(5'h00, 16'h2300);
    @(negedge clk);
    chk("R9 no strobe when disabled", {15'b0, anRestartStrobe}, 16'h0000);
    modeChk("R10 forced 100 full", 2'b11);
    wr(5'h00, 16'h0000); modeChk("R10 forced 10 half", 2'b00);
    wr(5'h00, 16'h7DFF);
    rdChk("R8 writable bits only", 5'h00, 16'h3100);
    wr(5'h00, 16'h2100);

    // short hardware pulse filtered
    hwPulse(5, 1'b0);
    rdChk("R1 short pulse ctrl kept", 5'h00, 16'h2100);
    rdChk("R1 short pulse partner kept", 5'h05, 16'h01E1);

    // software reset, straps changed on pins
    @(posedge clk); #2; strapIn = 4'b1110;
    wr(5'h00, 16'h8000);
    begin
      int hi = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (regRdData[15]) hi++;
      end
      chk("R3 reset bit length", 16'(hi), 16'(SWCYC));
    end
    rdChk("R2 sw reset uses kept straps", 5'h00, 16'h1000);
    rdChk("R3 adv defaulted", 5'h04, 16'h01E1);
    rdChk("R3 partner cleared", 5'h05, 16'h0000);
    wr(5'h00, 16'h8000);
    wr(5'h00, 16'h2100);
    repeat (12) @(posedge clk);
    rdChk("R3 write during reset ignored", 5'h00, 16'h1000);

    // hardware reset with new straps
    hwPulse(20, 1'b1);
    rdChk("R2 new strap ctrl", 5'h00, 16'h2100);
    rdChk("R2 new strap adv", 5'h04, 16'h0061);

    rdChk("R12 addr 02", 5'h02, 16'h0000);
    rdChk("R12 addr 1F", 5'h1F, 16'h0000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule